// File: doc/BRIEF.md
# Replica Compare and Fail-Stop Unit

This block receives 2K+1 copies of one data word. Each copy comes from a separate memory unit or processor lane. All copies arrive together as one parallel vector, qualified by a valid strobe. The block has two jobs, and a one-bit mode input picks between them on each transfer.

In check mode the block accepts a word only if every copy is identical. A single disagreement stops the unit for good. A sticky halt output rises, the result registers are cleared, and every later transfer is ignored until reset. Whatever the halted logic held is treated as lost.

In rebuild mode the block helps a peer recover the stored state of a unit that has stopped. It returns the value held by a strict majority of the copies, so up to K corrupted copies are outvoted. If no value reaches K+1 copies, it raises an error instead of returning data. In the same transfer it ORs the per-unit failed flags it was given, and reports the stopped peer as down if any flag is set. Every result appears exactly one clock after the valid input.

Top module: `rcf_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_valid`, `rd_data`, `halt`, `no_majority` and `peer_down` are all 0.
- R2: A valid check-mode transfer (`mode_sel` = 0) whose copies are all equal gives, one clock later, `rd_valid` = 1 and `rd_data` equal to the common value, with `halt` still 0.
- R3: A valid check-mode transfer in which any copy differs from any other sets `halt` one clock later. In that cycle `rd_valid` = 0 and `rd_data` = 0.
- R4: Once set, `halt` stays 1 until `rst`. While it is 1, every input is ignored: `rd_valid`, `no_majority` and `peer_down` stay 0 and `rd_data` stays 0.
- R5: A valid rebuild-mode transfer (`mode_sel` = 1) in which some value is held by at least K+1 copies gives, one clock later, `rd_valid` = 1, `rd_data` equal to that value, and `no_majority` = 0.
- R6: A valid rebuild-mode transfer in which no value is held by K+1 or more copies gives, one clock later, `no_majority` = 1, `rd_valid` = 0 and `rd_data` = 0.
- R7: One clock after a valid rebuild-mode transfer, `peer_down` equals the OR of `fail_flags`. After a check-mode transfer `peer_down` is 0. Disagreement in rebuild mode never sets `halt`.
- R8: One clock after a cycle with `in_valid` = 0, `rd_valid`, `rd_data`, `no_majority` and `peer_down` are 0, and `halt` keeps its value.
- R9: Copy i occupies bits [i*W +: W] of `copies`, and failed flag i is bit i of `fail_flags`. Any copy position can hold the deviating value, and voting gives the same result whatever its position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the only way to clear halt |
| in_valid | input | 1 | Qualifies copies, fail_flags and mode_sel this cycle |
| mode_sel | input | 1 | 0 = check for exact agreement, 1 = rebuild by majority |
| copies | input | (2K+1)*W | Replicated words, copy i at bits [i*W +: W] |
| fail_flags | input | 2K+1 | Failed flag read from each unit of a peer |
| rd_valid | output | 1 | Result word valid (one-cycle pulse) |
| rd_data | output | W | Agreed or majority word, zero when not valid |
| halt | output | 1 | Sticky fail-stop indication |
| no_majority | output | 1 | Rebuild found no value on K+1 copies |
| peer_down | output | 1 | OR of fail_flags for a rebuild transfer |

## Verification
The bench places the odd copy in the first lane, in the last lane and in the middle. A design that compared only neighbouring lanes, or dropped an end lane, would then accept a bad word instead of halting. In rebuild mode it uses patterns where the majority holds exactly K+1 copies and patterns where two equal-sized groups tie. An off-by-one threshold would either return a minority value or flag a valid majority as an error. After a halt it sends valid transfers in both modes, which shows whether halt leaks results or failed-flag reports. A rebuild transfer with disagreeing copies confirms that voting never stops the unit.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    typedef enum logic {
        MODE_CHECK   = 1'b0,
        MODE_REBUILD = 1'b1
    } rcf_mode_e;

    typedef struct packed {
        logic valid;
        logic nomaj;
        logic peer_down;
    } rcf_flags_t;

    localparam rcf_flags_t FLAGS_IDLE = '{valid: 1'b0, nomaj: 1'b0, peer_down: 1'b0};

    function automatic int unsigned lane_count(input int unsigned k);
        return 2 * k + 1;
    endfunction

endpackage

// File: rtl/rcf_agree.sv
module rcf_agree #(
    parameter int K = 1,
    parameter int W = 8
) (
    input  logic [(2*K+1)*W-1:0] copies,
    output logic                 all_same
);
    localparam int N = rcf_pkg::lane_count(K);

    logic [N-1:0] eq_ref;

    generate
        for (genvar i = 0; i < N; i++) begin : g_eq
            assign eq_ref[i] = (copies[i*W +: W] == copies[W-1:0]);
        end
    endgenerate

    assign all_same = &eq_ref;
endmodule

// File: rtl/rcf_vote.sv
module rcf_vote #(
    parameter int K = 1,
    parameter int W = 8
) (
    input  logic [(2*K+1)*W-1:0] copies,
    output logic                 found,
    output logic [W-1:0]         winner
);
    localparam int N  = rcf_pkg::lane_count(K);
    localparam int CW = $clog2(N + 1);

    logic [N-1:0] hit [N];
    logic [CW-1:0] votes [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_row
            for (genvar j = 0; j < N; j++) begin : g_col
                assign hit[i][j] = (copies[i*W +: W] == copies[j*W +: W]);
            end
            assign votes[i] = CW'($countones(hit[i]));
        end
    endgenerate

    always_comb begin
        found  = 1'b0;
        winner = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && (int'(votes[i]) >= K + 1)) begin
                found  = 1'b1;
                winner = copies[i*W +: W];
            end
        end
    end
endmodule

// File: rtl/rcf_unit.sv
module rcf_unit #(
    parameter int K = 1,
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 mode_sel,
    input  logic [(2*K+1)*W-1:0] copies,
    input  logic [2*K:0]         fail_flags,
    output logic                 rd_valid,
    output logic [W-1:0]         rd_data,
    output logic                 halt,
    output logic                 no_majority,
    output logic                 peer_down
);
    import rcf_pkg::*;

    rcf_mode_e  mode;
    logic       agree;
    logic       maj_found;
    logic [W-1:0] maj_value;
    rcf_flags_t flags_q;
    logic [W-1:0] data_q;
    logic       halt_q;

    assign mode = rcf_mode_e'(mode_sel);

    rcf_agree #(.K(K), .W(W)) agree_i (
        .copies   (copies),
        .all_same (agree)
    );

    rcf_vote #(.K(K), .W(W)) vote_i (
        .copies (copies),
        .found  (maj_found),
        .winner (maj_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= FLAGS_IDLE;
            data_q  <= '0;
            halt_q  <= 1'b0;
        end else if (halt_q || !in_valid) begin
            flags_q <= FLAGS_IDLE;
            data_q  <= '0;
        end else if (mode == MODE_CHECK) begin
            flags_q.nomaj     <= 1'b0;
            flags_q.peer_down <= 1'b0;
            flags_q.valid     <= agree;
            data_q            <= agree ? copies[W-1:0] : '0;
            halt_q            <= !agree;
        end else begin
            flags_q.valid     <= maj_found;
            flags_q.nomaj     <= !maj_found;
            flags_q.peer_down <= |fail_flags;
            data_q            <= maj_found ? maj_value : '0;
        end
    end

    assign rd_valid    = flags_q.valid;
    assign rd_data     = data_q;
    assign no_majority = flags_q.nomaj;
    assign peer_down   = flags_q.peer_down;
    assign halt        = halt_q;
endmodule

// File: rtl/rcf_unit_chk.sv
module rcf_unit_chk #(
    parameter int K = 1,
    parameter int W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 mode_sel,
    input logic [(2*K+1)*W-1:0] copies,
    input logic [2*K:0]         fail_flags,
    input logic                 rd_valid,
    input logic [W-1:0]         rd_data,
    input logic                 halt,
    input logic                 no_majority,
    input logic                 peer_down
);
    a_r4_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

    a_r4_silent_when_halted: assert property (@(posedge clk) disable iff (rst)
        halt |=> (!rd_valid && !no_majority && !peer_down && rd_data == '0));

    a_r3_halt_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(halt) |-> ($past(in_valid) && !$past(mode_sel)));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && no_majority));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!rd_valid && !no_majority && !peer_down));

    a_r2_check_data: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_sel && !halt) |=> (rd_valid -> rd_data == $past(copies[W-1:0])));

    a_r7_peer_flag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_sel && !halt) |=> (peer_down == $past(|fail_flags)));
endmodule

bind rcf_unit rcf_unit_chk #(.K(K), .W(W)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_sel(mode_sel),
    .copies(copies), .fail_flags(fail_flags), .rd_valid(rd_valid),
    .rd_data(rd_data), .halt(halt), .no_majority(no_majority),
    .peer_down(peer_down)
);

// File: tb/rcf_unit_tb_top.sv
module rcf_unit_tb_top;
    localparam int K = 2;
    localparam int W = 8;
    localparam int N = 2 * K + 1;
    localparam int OW = W + 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic mode_sel = 1'b0;
    logic [N*W-1:0] copies = '0;
    logic [N-1:0] fail_flags = '0;
    logic rd_valid, halt, no_majority, peer_down;
    logic [W-1:0] rd_data;

    always #5 clk = ~clk;

    rcf_unit #(.K(K), .W(W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_sel(mode_sel),
        .copies(copies), .fail_flags(fail_flags), .rd_valid(rd_valid),
        .rd_data(rd_data), .halt(halt), .no_majority(no_majority),
        .peer_down(peer_down)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit m_halt = 1'b0;
    bit have_exp = 1'b0;
    logic [OW-1:0] exp_vec;
    string exp_tag;
    bit finished = 1'b0;

    // Packs outputs as {rd_valid, halt, no_majority, peer_down, rd_data}
    function automatic logic [OW-1:0] pack_out(bit v, bit h, bit nm, bit pd, logic [W-1:0] d);
        return {v, h, nm, pd, d};
    endfunction

    task automatic step(input bit r, input bit v, input bit m,
                        input logic [N*W-1:0] c, input logic [N-1:0] f,
                        input string tag);
        bit ev, enm, epd, found;
        logic [W-1:0] ed;
        int cnt;
        @(negedge clk);
        if (have_exp) begin
            logic [OW-1:0] act;
            act = pack_out(rd_valid, halt, no_majority, peer_down, rd_data);
            n_cmp++;
            if (act !== exp_vec) begin
                n_bad++;
                $display("FAIL %s: actual=%h expected=%h (valid,halt,nomaj,peer,data)",
                         exp_tag, act, exp_vec);
            end
        end
        rst = r; in_valid = v; mode_sel = m; copies = c; fail_flags = f;
        ev = 0; enm = 0; epd = 0; ed = '0;
        if (r) m_halt = 0;
        else if (!m_halt && v) begin
            if (!m) begin
                found = 1;
                for (int i = 0; i < N; i++)
                    if (c[i*W +: W] != c[W-1:0]) found = 0;
                if (found) begin ev = 1; ed = c[W-1:0]; end
                else m_halt = 1;
            end else begin
                found = 0;
                for (int i = 0; i < N; i++) begin
                    cnt = 0;
                    for (int j = 0; j < N; j++)
                        if (c[i*W +: W] == c[j*W +: W]) cnt++;
                    if (!found && cnt > K) begin found = 1; ed = c[i*W +: W]; end
                end
                ev = found; enm = !found; epd = |f;
            end
        end
        exp_vec = pack_out(ev, m_halt, enm, epd, ed);
        exp_tag = tag;
        have_exp = 1;
    endtask

    function automatic logic [N*W-1:0] fill(logic [W-1:0] val);
        logic [N*W-1:0] x;
        for (int i = 0; i < N; i++) x[i*W +: W] = val;
        return x;
    endfunction

    function automatic logic [N*W-1:0] poke(logic [N*W-1:0] x, int lane, logic [W-1:0] val);
        logic [N*W-1:0] y;
        y = x;
        y[lane*W +: W] = val;
        return y;
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] c;
        step(1, 0, 0, '0, '0, "R1 reset");
        step(1, 0, 0, fill(8'hA5), '1, "R1 reset held");
        step(0, 0, 0, '0, '0, "R1 after reset");
        // R2: agreement accepted
        step(0, 1, 0, fill(8'h3C), '0, "R2 agree 3C");
        step(0, 1, 0, fill(8'hFF), '1, "R2 agree FF R7 check clears peer");
        step(0, 1, 0, fill(8'h00), '0, "R2 agree 00");
        // R8: idle gap
        step(0, 0, 1, fill(8'h11), '1, "R8 idle");
        // R5/R9: majority with K bad copies at varying positions
        c = poke(poke(fill(8'h5A), 0, 8'h01), 1, 8'h02);
        step(0, 1, 1, c, 5'b00000, "R5 R9 bad lanes 0,1");
        c = poke(poke(fill(8'h77), 4, 8'h99), 3, 8'h99);
        step(0, 1, 1, c, 5'b10000, "R5 R9 bad lanes 3,4 R7 flag4");
        c = poke(poke(fill(8'hC3), 2, 8'h00), 0, 8'hFF);
        step(0, 1, 1, c, 5'b00100, "R5 R9 bad lanes 0,2 R7 flag2");
        // R6: no strict majority
        c = {8'h01, 8'h01, 8'h02, 8'h02, 8'h03};
        step(0, 1, 1, c, 5'b00001, "R6 tie 2-2-1");
        c = {8'h10, 8'h20, 8'h30, 8'h40, 8'h50};
        step(0, 1, 1, c, 5'b00000, "R6 all distinct");
        // Random rebuild traffic, R5/R6/R7 and R7 no halt from vote
        for (int t = 0; t < 60; t++) begin
            logic [N*W-1:0] rc;
            for (int i = 0; i < N; i++) rc[i*W +: W] = W'($urandom_range(0, 3));
            step(0, 1, 1, rc, N'($urandom), "R7 R5 R6 random rebuild");
        end
        step(0, 1, 0, fill(8'h6E), '0, "R7 no halt after votes");
        // R3: mismatch in the last lane
        step(0, 1, 0, poke(fill(8'h42), N-1, 8'h43), '0, "R3 last lane differs");
        // R4: halted unit ignores everything
        step(0, 1, 0, fill(8'h42), '0, "R4 halted check");
        step(0, 1, 1, fill(8'h42), '1, "R4 halted rebuild");
        step(0, 0, 0, '0, '0, "R4 halted idle");
        // Reset clears halt
        step(1, 0, 0, '0, '0, "R4 reset clears");
        step(0, 1, 0, poke(fill(8'h42), 0, 8'h00), '0, "R3 R9 first lane differs");
        step(0, 1, 1, fill(8'h42), '1, "R4 halted rebuild 2");
        step(1, 0, 0, '0, '0, "R1 reset again");
        step(0, 1, 0, poke(fill(8'h81), K, 8'h80), '0, "R3 R9 middle lane differs");
        step(0, 0, 0, '0, '0, "R4 stays halted");
        step(0, 0, 0, '0, '0, "R4 final");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule